// File: doc/BRIEF.md
# Keyed Disk Register Gate with DMA Launcher

This block sits between a register bus and a disk-interface register file. Access to the disk registers is locked until software writes a specific 32-bit unlock key to an activation register, and a second key locks it again. While locked, disk register writes are dropped and disk register reads return all ones. While unlocked, reads pass straight through. Writes to the data and device-control registers also pass straight through. Writes to the task-file registers are forwarded only when the device reports that it can take register writes. A command write is also forwarded whenever it carries the no-operation code.

Next to the gate is a DMA launch controller. It holds a transfer address, a length, a direction bit, an arm register and a go register, plus a read-only count of the bytes moved. A write of 1 to go while arm holds 1 starts a transfer: the controller raises a level request toward an external data mover and holds it until the mover pulses done with a byte count. These DMA registers can be reached whether or not the disk registers are unlocked. Bus reads are combinational; writes take effect at the clock edge.

Top module: `disk_reg_gate`

## Requirements
- R1: After reset the disk registers are locked, no DMA request is raised, and the go, arm, address, length, direction and moved-count registers read 0.
- R2: A write of 0x001FFFFF to the key register (address 22) unlocks the disk registers, and a write of 0x000042FE locks them. Any other value leaves the lock state unchanged. Bit 0 of a key register read gives the unlock state, and all other bits read 0.
- R3: While locked, a write to a disk register (addresses 0 to 8) does not assert dev_wr_o. A read of a disk register does not assert dev_rd_o and returns 0xFFFFFFFF.
- R4: While unlocked, a disk register read asserts dev_rd_o and returns dev_rdata_i. Writes to device control (0) and data (1) assert dev_wr_o with the full write word.
- R5: While unlocked, a write to a task-file register (addresses 2 to 7) asserts dev_wr_o only when dev_regs_ok_i is 1, with dev_wdata_o equal to the low 8 bits of the write zero-extended.
- R6: While unlocked, a write to the command register (address 8) is forwarded when dev_regs_ok_i is 1 or when the whole write word equals 0x00000000 (the no-operation code), with the low 8 bits zero-extended.
- R7: The DMA address (16), length (17), direction (18, bit 0 only) and arm (19) registers read back what was last written, whatever the lock state.
- R8: A write of 1 to go (20) while arm holds 1 raises dma_req_o at the next edge, clears the moved count (21) to 0, leaves go reading 1, and presents the stored address, length and direction on the DMA outputs.
- R9: A write of 1 to go while arm does not hold 1 leaves go reading 0 and raises no request.
- R10: A dma_done_i pulse while a request is raised loads dma_count_i into the moved count, returns go to 0 and drops dma_req_o at that edge. A done pulse with no request raised has no effect.
- R11: While a request is raised, writes to the address, length, direction, arm and go registers are ignored.
- R12: A write to go of any value other than 1, with no request raised, stores that value and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 5 | Register word index |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational |
| dev_wr_o | output | 1 | Forwarded disk register write |
| dev_rd_o | output | 1 | Forwarded disk register read |
| dev_addr_o | output | 4 | Disk register index |
| dev_wdata_o | output | 32 | Forwarded write data |
| dev_rdata_i | input | 32 | Disk register read data |
| dev_regs_ok_i | input | 1 | Device can take task-file writes |
| dma_req_o | output | 1 | Transfer request, held until done |
| dma_addr_o | output | 32 | Transfer address |
| dma_len_o | output | 32 | Transfer length |
| dma_dir_o | output | 1 | Transfer direction |
| dma_done_i | input | 1 | Transfer complete pulse |
| dma_count_i | input | 32 | Bytes moved, valid with done |

## Verification
The assertions assume that read and write strobes never fire in the same cycle, and that the data mover pulses dma_done_i for a single cycle and only while a request is raised. The hold check also relies on the DMA registers changing only through bus writes. The stimulus issues one bus operation at a time. It drives dma_done_i only from a task that pulses it for one cycle. It mixes random key values, including both real keys, with random task-file and command writes under random device readiness. About a quarter of the command words are zero, so the no-operation path gets regular traffic.

// File: rtl/disk_gate_pkg.sv
package disk_gate_pkg;
  localparam int ADDR_W     = 5;
  localparam int DEV_ADDR_W = 4;
  localparam int NUM_DISK   = 9;

  localparam logic [ADDR_W-1:0] REG_DEVCTL = 5'd0;
  localparam logic [ADDR_W-1:0] REG_DATA   = 5'd1;
  localparam logic [ADDR_W-1:0] REG_TF_LO  = 5'd2;
  localparam logic [ADDR_W-1:0] REG_TF_HI  = 5'd7;
  localparam logic [ADDR_W-1:0] REG_CMD    = 5'd8;
  localparam logic [ADDR_W-1:0] REG_DADDR  = 5'd16;
  localparam logic [ADDR_W-1:0] REG_DLEN   = 5'd17;
  localparam logic [ADDR_W-1:0] REG_DDIR   = 5'd18;
  localparam logic [ADDR_W-1:0] REG_ARM    = 5'd19;
  localparam logic [ADDR_W-1:0] REG_GO     = 5'd20;
  localparam logic [ADDR_W-1:0] REG_MOVED  = 5'd21;
  localparam logic [ADDR_W-1:0] REG_KEY    = 5'd22;
endpackage

// File: rtl/disk_key_ctrl.sv
module disk_key_ctrl
  import disk_gate_pkg::*;
#(
  parameter int                DATA_W  = 32,
  parameter logic [DATA_W-1:0] KEY_ON  = 32'h001F_FFFF,
  parameter logic [DATA_W-1:0] KEY_OFF = 32'h0000_42FE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              en_o
);
  logic key_wr;
  assign key_wr = wr_i && (addr_i == REG_KEY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            en_o <= 1'b0;
    else if (key_wr && wdata_i == KEY_ON)   en_o <= 1'b1;
    else if (key_wr && wdata_i == KEY_OFF)  en_o <= 1'b0;
  end

  // R2
  key_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_wr && wdata_i == KEY_ON |=> en_o);
  // R2
  key_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_wr && wdata_i == KEY_OFF |=> !en_o);
  // R2
  key_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(key_wr && (wdata_i == KEY_ON || wdata_i == KEY_OFF)) |=> $stable(en_o));
endmodule

// File: rtl/disk_access_gate.sv
module disk_access_gate
  import disk_gate_pkg::*;
#(
  parameter int                DATA_W  = 32,
  parameter logic [DATA_W-1:0] NOP_CMD = '0
) (
  input  logic              en_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              regs_ok_i,
  output logic              disk_sel_o,
  output logic              dev_wr_o,
  output logic              dev_rd_o,
  output logic [DATA_W-1:0] dev_wdata_o
);
  logic is_tf, is_cmd;
  logic [DATA_W-1:0] byte_word;

  assign disk_sel_o = (addr_i < ADDR_W'(NUM_DISK));
  assign is_tf      = (addr_i >= REG_TF_LO) && (addr_i <= REG_TF_HI);
  assign is_cmd     = (addr_i == REG_CMD);
  assign byte_word  = {{(DATA_W-8){1'b0}}, wdata_i[7:0]};
  assign dev_rd_o   = en_i && rd_i && disk_sel_o;

  always_comb begin
    dev_wr_o    = 1'b0;
    dev_wdata_o = wdata_i;
    if (en_i && wr_i && disk_sel_o) begin
      if (is_tf) begin
        dev_wr_o    = regs_ok_i;
        dev_wdata_o = byte_word;
      end else if (is_cmd) begin
        dev_wr_o    = regs_ok_i || (wdata_i == NOP_CMD);
        dev_wdata_o = byte_word;
      end else begin
        dev_wr_o    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/disk_dma_launch.sv
module disk_dma_launch
  import disk_gate_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              dma_done_i,
  input  logic [DATA_W-1:0] dma_count_i,
  output logic              dma_req_o,
  output logic [DATA_W-1:0] dma_addr_o,
  output logic [DATA_W-1:0] dma_len_o,
  output logic              dma_dir_o,
  output logic [DATA_W-1:0] arm_o,
  output logic [DATA_W-1:0] go_o,
  output logic [DATA_W-1:0] moved_o
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic busy_q;
  assign dma_req_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      dma_addr_o <= '0;
      dma_len_o  <= '0;
      dma_dir_o  <= 1'b0;
      arm_o      <= '0;
      go_o       <= '0;
      moved_o    <= '0;
    end else if (busy_q) begin
      // register writes are dropped until the mover reports back
      if (dma_done_i) begin
        moved_o <= dma_count_i;
        go_o    <= '0;
        busy_q  <= 1'b0;
      end
    end else if (wr_i) begin
      unique case (addr_i)
        REG_DADDR: dma_addr_o <= wdata_i;
        REG_DLEN:  dma_len_o  <= wdata_i;
        REG_DDIR:  dma_dir_o  <= wdata_i[0];
        REG_ARM:   arm_o      <= wdata_i;
        REG_GO: begin
          if (wdata_i != ONE) go_o <= wdata_i;
          else if (arm_o == ONE) begin
            go_o    <= ONE;
            moved_o <= '0;
            busy_q  <= 1'b1;
          end else go_o <= '0;
        end
        default: ;
      endcase
    end
  end

  // R8
  start_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(arm_o == ONE && wr_i && addr_i == REG_GO && wdata_i == ONE));
  // R8
  start_moved_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> moved_o == '0 && go_o == ONE);
  // R9
  no_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q && wr_i && addr_i == REG_GO && wdata_i == ONE && arm_o != ONE
    |=> !busy_q && go_o == '0);
  // R10
  done_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && dma_done_i |=> !busy_q && go_o == '0 && moved_o == $past(dma_count_i));
  // R11
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !dma_done_i |=> $stable(dma_addr_o) && $stable(dma_len_o)
                             && $stable(dma_dir_o) && $stable(arm_o) && $stable(go_o));
endmodule

// File: rtl/disk_reg_gate.sv
module disk_reg_gate
  import disk_gate_pkg::*;
#(
  parameter int                DATA_W  = 32,
  parameter logic [DATA_W-1:0] KEY_ON  = 32'h001F_FFFF,
  parameter logic [DATA_W-1:0] KEY_OFF = 32'h0000_42FE,
  parameter logic [DATA_W-1:0] NOP_CMD = '0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  bus_wr_i,
  input  logic                  bus_rd_i,
  input  logic [ADDR_W-1:0]     bus_addr_i,
  input  logic [DATA_W-1:0]     bus_wdata_i,
  output logic [DATA_W-1:0]     bus_rdata_o,
  output logic                  dev_wr_o,
  output logic                  dev_rd_o,
  output logic [DEV_ADDR_W-1:0] dev_addr_o,
  output logic [DATA_W-1:0]     dev_wdata_o,
  input  logic [DATA_W-1:0]     dev_rdata_i,
  input  logic                  dev_regs_ok_i,
  output logic                  dma_req_o,
  output logic [DATA_W-1:0]     dma_addr_o,
  output logic [DATA_W-1:0]     dma_len_o,
  output logic                  dma_dir_o,
  input  logic                  dma_done_i,
  input  logic [DATA_W-1:0]     dma_count_i
);
  logic              en, disk_sel;
  logic [DATA_W-1:0] arm, go, moved;

  assign dev_addr_o = bus_addr_i[DEV_ADDR_W-1:0];

  disk_key_ctrl #(.DATA_W(DATA_W), .KEY_ON(KEY_ON), .KEY_OFF(KEY_OFF)) u_key (
    .clk_i, .rst_ni, .wr_i(bus_wr_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .en_o(en));

  disk_access_gate #(.DATA_W(DATA_W), .NOP_CMD(NOP_CMD)) u_gate (
    .en_i(en), .wr_i(bus_wr_i), .rd_i(bus_rd_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .regs_ok_i(dev_regs_ok_i), .disk_sel_o(disk_sel),
    .dev_wr_o, .dev_rd_o, .dev_wdata_o);

  disk_dma_launch #(.DATA_W(DATA_W)) u_dma (
    .clk_i, .rst_ni, .wr_i(bus_wr_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .dma_done_i, .dma_count_i, .dma_req_o, .dma_addr_o, .dma_len_o, .dma_dir_o,
    .arm_o(arm), .go_o(go), .moved_o(moved));

  always_comb begin
    bus_rdata_o = '0;
    if (disk_sel) bus_rdata_o = en ? dev_rdata_i : '1;
    else begin
      case (bus_addr_i)
        REG_DADDR: bus_rdata_o = dma_addr_o;
        REG_DLEN:  bus_rdata_o = dma_len_o;
        REG_DDIR:  bus_rdata_o = {{(DATA_W-1){1'b0}}, dma_dir_o};
        REG_ARM:   bus_rdata_o = arm;
        REG_GO:    bus_rdata_o = go;
        REG_MOVED: bus_rdata_o = moved;
        REG_KEY:   bus_rdata_o = {{(DATA_W-1){1'b0}}, en};
        default:   bus_rdata_o = '0;
      endcase
    end
  end

  // R3
  locked_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> !dev_wr_o && !dev_rd_o);
  // R5
  tf_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_wr_o && bus_addr_i >= REG_TF_LO && bus_addr_i <= REG_TF_HI
    |-> dev_regs_ok_i && dev_wdata_o[DATA_W-1:8] == '0);
  // R6
  cmd_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_wr_o && bus_addr_i == REG_CMD |-> dev_regs_ok_i || bus_wdata_i == NOP_CMD);
  // R4
  rd_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_rd_o |-> bus_rdata_o == dev_rdata_i);
endmodule

// File: tb/disk_reg_gate_tb_top.sv
module disk_reg_gate_tb_top;
  localparam logic [31:0] K_ON = 32'h001F_FFFF, K_OFF = 32'h0000_42FE;

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic bus_wr = 0, bus_rd = 0, regs_ok = 0, done = 0;
  logic [4:0] addr = 0;
  logic [31:0] wdata = 0, rdata, dev_wdata, dev_rdata = 0, d_addr, d_len, count = 0;
  logic dev_wr, dev_rd, req, d_dir;
  logic [3:0] dev_addr;

  disk_reg_gate dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .dev_wr_o(dev_wr), .dev_rd_o(dev_rd),
    .dev_addr_o(dev_addr), .dev_wdata_o(dev_wdata), .dev_rdata_i(dev_rdata),
    .dev_regs_ok_i(regs_ok), .dma_req_o(req), .dma_addr_o(d_addr), .dma_len_o(d_len),
    .dma_dir_o(d_dir), .dma_done_i(done), .dma_count_i(count));

  int n_chk = 0, n_bad = 0;
  bit m_en = 0, m_busy = 0, m_dir = 0;
  logic [31:0] m_addr = 0, m_len = 0, m_arm = 0, m_go = 0, m_moved = 0;

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic bit exp_fwd(input logic [4:0] a, input logic [31:0] d, input bit en, input bit ok);
    if (!en || a > 8) return 0;
    if (a >= 2 && a <= 7) return ok;
    if (a == 8) return ok || d == 0;
    return 1;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [4:0] a, input logic [31:0] dr);
    if (a <= 8) return m_en ? dr : 32'hFFFF_FFFF;
    case (a)
      16: return m_addr;  17: return m_len;  18: return {31'b0, m_dir};
      19: return m_arm;   20: return m_go;   21: return m_moved;
      22: return {31'b0, m_en};
      default: return 0;
    endcase
  endfunction

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input bit ok, input string r);
    bit ef;
    @(negedge clk);
    bus_wr = 1; addr = a; wdata = d; regs_ok = ok;
    #1;
    ef = exp_fwd(a, d, m_en, ok);
    if (a <= 8) begin
      chk(dev_wr == ef, r, {31'b0, dev_wr}, {31'b0, ef});
      if (ef) chk(dev_wdata == ((a >= 2) ? {24'b0, d[7:0]} : d), r, dev_wdata,
                  (a >= 2) ? {24'b0, d[7:0]} : d);
    end
    @(posedge clk); #1;
    bus_wr = 0;
    if (a == 22) begin
      if (d == K_ON) m_en = 1; else if (d == K_OFF) m_en = 0;
    end
    if (!m_busy) case (a)
      16: m_addr = d;  17: m_len = d;  18: m_dir = d[0];  19: m_arm = d;
      20: if (d != 1) m_go = d;
          else if (m_arm == 1) begin m_go = 1; m_moved = 0; m_busy = 1; end
          else m_go = 0;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [4:0] a, input string r);
    logic [31:0] e;
    @(negedge clk);
    bus_rd = 1; addr = a; dev_rdata = $urandom;
    #1;
    e = exp_rd(a, dev_rdata);
    chk(rdata == e, r, rdata, e);
    chk(dev_rd == (m_en && a <= 8), r, {31'b0, dev_rd}, {31'b0, m_en && a <= 8});
    bus_rd = 0;
  endtask

  task automatic pulse_done(input logic [31:0] c);
    @(negedge clk);
    done = 1; count = c;
    @(posedge clk); #1;
    done = 0;
    if (m_busy) begin m_moved = c; m_go = 0; m_busy = 0; end
  endtask

  task automatic chk_req(input string r);
    chk(req == m_busy, r, {31'b0, req}, {31'b0, m_busy});
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk_req("R1");
    for (int a = 16; a <= 22; a++) rd(5'(a), "R1");
    rd(5'd3, "R1 locked read");
    // R3 locked writes
    wr(5'd1, 32'hDEAD_BEEF, 1, "R3");
    wr(5'd8, 32'h0, 1, "R3");
    // R2 bad key keeps lock, good key unlocks
    wr(5'd22, 32'h001F_FFFE, 0, "R2"); rd(5'd22, "R2");
    wr(5'd22, K_ON, 0, "R2");          rd(5'd22, "R2");
    // R4 pass-through
    wr(5'd0, 32'hA5A5_1234, 0, "R4");
    rd(5'd5, "R4");
    // R5 task-file gated by readiness
    wr(5'd4, 32'h1234_56C3, 0, "R5");
    wr(5'd4, 32'h1234_56C3, 1, "R5");
    // R6 command: NOP passes, other blocked, ready passes
    wr(5'd8, 32'h0, 0, "R6");
    wr(5'd8, 32'hA0, 0, "R6");
    wr(5'd8, 32'h100, 0, "R6 not nop");
    wr(5'd8, 32'hEC, 1, "R6");
    wr(5'd22, K_OFF, 0, "R2"); rd(5'd22, "R2"); rd(5'd1, "R3");

    // R7 DMA regs while locked
    wr(5'd16, 32'h0C00_1000, 0, "R7"); wr(5'd17, 32'h200, 0, "R7");
    wr(5'd18, 32'hFFFF_FFFF, 0, "R7"); wr(5'd19, 32'h0, 0, "R7");
    for (int a = 16; a <= 19; a++) rd(5'(a), "R7");
    // R9 go without arm
    wr(5'd20, 32'h1, 0, "R9"); rd(5'd20, "R9"); chk_req("R9");
    // R12 other go value stored
    wr(5'd20, 32'h5, 0, "R12"); rd(5'd20, "R12"); chk_req("R12");
    wr(5'd20, 32'h0, 0, "R12");
    // R10 stray done
    pulse_done(32'h77); rd(5'd21, "R10 stray");
    // R8 first transfer
    wr(5'd19, 32'h1, 0, "R8"); wr(5'd20, 32'h1, 0, "R8");
    chk_req("R8"); rd(5'd20, "R8"); rd(5'd21, "R8");
    chk(d_addr == 32'h0C00_1000, "R8", d_addr, 32'h0C00_1000);
    chk(d_len == 32'h200, "R8", d_len, 32'h200);
    chk(d_dir == 1'b1, "R8", {31'b0, d_dir}, 32'h1);
    // R11 writes ignored while busy
    wr(5'd16, 32'h1111_1111, 0, "R11"); wr(5'd20, 32'h0, 0, "R11");
    wr(5'd19, 32'h0, 0, "R11");
    rd(5'd16, "R11"); rd(5'd20, "R11"); rd(5'd19, "R11"); chk_req("R11");
    // R10 completion
    pulse_done(32'h1F0); chk_req("R10"); rd(5'd21, "R10"); rd(5'd20, "R10");
    // R8 second transfer clears moved count
    wr(5'd20, 32'h1, 0, "R8"); rd(5'd21, "R8"); chk_req("R8");
    pulse_done(32'h40); rd(5'd21, "R10");

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 4);
      case (op)
        0: begin
          int k = $urandom_range(0, 2);
          wr(5'd22, (k == 0) ? K_ON : (k == 1) ? K_OFF : $urandom, 0, "R2");
          rd(5'd22, "R2");
        end
        1: begin
          logic [4:0] a = 5'($urandom_range(0, 8));
          logic [31:0] d = ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom;
          wr(a, d, 1'($urandom_range(0, 1)), (a == 8) ? "R6" : (a >= 2) ? "R5" : "R4");
        end
        2: rd(5'($urandom_range(0, 8)), "R3/R4 read");
        3: begin
          logic [4:0] a = 5'($urandom_range(16, 19));
          wr(a, (a == 19) ? 32'($urandom_range(0, 2)) : $urandom, 0, "R7");
          rd(a, "R7");
        end
        default: rd(5'($urandom_range(16, 22)), "R7");
      endcase
    end
    finish_run();
  end
endmodule